// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the 32-bit register storage of a processor core. At any moment it presents sixteen architectural registers, addressed by a 4-bit index. Behind that view sits a larger set of physical registers. The 5-bit processor mode input decides which physical copy answers for each index. Indices 0 to 12 are general purpose, 13 is the stack pointer, 14 is the link register and 15 is the program counter.

The fast-interrupt mode swaps in private copies of indices 8 through 14. The normal-interrupt, supervisor, abort and undefined modes each swap in private copies of indices 13 and 14 only. User mode and the privileged system mode share one set of registers. Index 15 is a single register shared by every mode. There are two combinational read ports and one write port that takes effect on the clock edge.

The block also holds the current status register and one saved status register for each of the five exception modes. The mode input selects which saved register the saved-status port reaches. The mode input is the only thing that selects banks; the mode field of the current status register is just stored data.

Top module: `banked_regfile`

## Requirements
- R1: After reset every architectural register reads zero in every mode, every saved status register reads zero, and the current status register reads 0x00000013 (the supervisor encoding in bits 4:0).
- R2: Indices 0 to 7 name the same physical registers in every mode.
- R3: In fast-interrupt mode (mode 10001), indices 8 to 14 reach private registers. Every other mode reaches the user copies of indices 8 to 12.
- R4: Normal-interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have their own private copies of indices 13 and 14.
- R5: System mode (11111) reaches exactly the registers of user mode (10000). Any mode value outside the seven listed encodings also selects the user registers.
- R6: Index 15 is one register shared by all modes.
- R7: A write with wr_en high stores wr_data into the register that wr_idx names in the current mode, at the rising clock edge. A read of that register in the same cycle returns the old value, and the new value appears from the next cycle.
- R8: Each exception mode has its own saved status register. A saved-status write in one exception mode changes only that mode's copy, and the new value is readable from the next cycle.
- R9: In user, system or unlisted modes, the saved-status read port returns the current status register and a saved-status write is ignored.
- R10: A current-status write is visible from the next cycle and is seen the same way in every mode.
- R11: The two read ports are independent: each returns the register that its own index names, and both may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Processor mode that selects the bank |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| st_wr_en | input | 1 | Current status write enable |
| st_wr_data | input | 32 | Current status write data |
| st_rd_data | output | 32 | Current status value |
| sv_wr_en | input | 1 | Saved status write enable, for the current mode |
| sv_wr_data | input | 32 | Saved status write data |
| sv_rd_data | output | 32 | Saved status of the current mode, or current status in modes without one |

## Verification
The bench writes the same index under one mode and reads it back under others. A mapping that does not bank index 8 for fast interrupts, or that gives system mode its own stack pointer, returns a stale or zero value at one of those reads. It also reads a register in the same cycle it is written. A design that forwards the write returns the new value there instead of the old one. Saved-status writes in user mode followed by a read back in supervisor mode catch a design that lets the ignored write land in some bank. An unlisted mode encoding is driven to check that it falls back to the user registers and does not reach an undefined slot.

// File: rtl/bank_pkg.sv
package bank_pkg;

   localparam int ARCH_IDX_W = 4;
   localparam int MODE_W     = 5;
   localparam int SP_IDX     = 13;
   localparam int LR_IDX     = 14;
   localparam int PC_IDX     = 15;

   localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

   // Physical bank identity; user-class banks first, exception banks after.
   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5
   } bank_e;

   localparam int NUM_BANKS = 6;
   localparam int NUM_EXC   = NUM_BANKS - 1;

endpackage

// File: rtl/bank_mode_decode.sv
module bank_mode_decode
   import bank_pkg::*;
#(
   parameter int MODE_BITS = 5
) (
   input  logic [MODE_BITS-1:0] mode_i,
   output bank_e                bank_o
);

   if (MODE_BITS != MODE_W) begin : g_bad_mode_w
      $error("bank_mode_decode: MODE_BITS must equal the package mode width");
   end

   always_comb begin
      unique case (mode_i)
         MD_FIQ:  bank_o = BK_FIQ;
         MD_IRQ:  bank_o = BK_IRQ;
         MD_SVC:  bank_o = BK_SVC;
         MD_ABT:  bank_o = BK_ABT;
         MD_UND:  bank_o = BK_UND;
         default: bank_o = BK_USR;   // user, system and unlisted codes
      endcase
   end

endmodule

// File: rtl/bank_gpr_store.sv
module bank_gpr_store
   import bank_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int RD_PORTS = 2,
   parameter int FIQ_LO   = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  bank_e                                bank,
   input  logic                                 wr_en,
   input  logic [ARCH_IDX_W-1:0]                wr_idx,
   input  logic [DATA_W-1:0]                    wr_data,
   input  logic [RD_PORTS-1:0][ARCH_IDX_W-1:0]  rd_idx,
   output logic [RD_PORTS-1:0][DATA_W-1:0]      rd_data
);

   localparam int HI_CNT      = SP_IDX - FIQ_LO;
   localparam int USR_HI_BASE = FIQ_LO;
   localparam int FIQ_HI_BASE = USR_HI_BASE + HI_CNT;
   localparam int SPLR_BASE   = FIQ_HI_BASE + HI_CNT;
   localparam int PC_SLOT     = SPLR_BASE + 2 * NUM_BANKS;
   localparam int NPHYS       = PC_SLOT + 1;
   localparam int PIDX_W      = $clog2(NPHYS);

   if (DATA_W < 1) begin : g_bad_width
      $error("bank_gpr_store: DATA_W must be positive");
   end
   if (RD_PORTS < 1) begin : g_bad_ports
      $error("bank_gpr_store: at least one read port is needed");
   end
   if (FIQ_LO < 1 || FIQ_LO > SP_IDX) begin : g_bad_lo
      $error("bank_gpr_store: FIQ_LO must lie within the general registers");
   end

   // Architectural index plus bank to physical slot.
   function automatic logic [PIDX_W-1:0] phys_of(input bank_e b,
                                                 input logic [ARCH_IDX_W-1:0] idx);
      int i;
      int r;
      i = int'(idx);
      if (i < FIQ_LO)
         r = i;
      else if (i < SP_IDX)
         r = ((b == BK_FIQ) ? FIQ_HI_BASE : USR_HI_BASE) + (i - FIQ_LO);
      else if (i < PC_IDX)
         r = SPLR_BASE + 2 * int'(b) + (i - SP_IDX);
      else
         r = PC_SLOT;
      return PIDX_W'(r);
   endfunction

   logic [DATA_W-1:0] regs [NPHYS];
   logic [PIDX_W-1:0] wr_slot;

   assign wr_slot = phys_of(bank, wr_idx);

   for (genvar g = 0; g < NPHYS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && wr_slot == PIDX_W'(g))
            regs[g] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      logic [PIDX_W-1:0] slot;
      logic [DATA_W-1:0] sel;
      assign slot = phys_of(bank, rd_idx[p]);
      always_comb begin
         sel = '0;
         for (int k = 0; k < NPHYS; k++) begin
            if (slot == PIDX_W'(k))
               sel = regs[k];
         end
      end
      assign rd_data[p] = sel;
   end

endmodule

// File: rtl/bank_psr_store.sv
module bank_psr_store
   import bank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_e             bank,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   output logic [DATA_W-1:0] st_rd_data,
   input  logic              sv_wr_en,
   input  logic [DATA_W-1:0] sv_wr_data,
   output logic [DATA_W-1:0] sv_rd_data
);

   if (DATA_W < MODE_W) begin : g_bad_width
      $error("bank_psr_store: DATA_W must hold the mode field");
   end

   localparam logic [DATA_W-1:0] CUR_RESET = {{(DATA_W-MODE_W){1'b0}}, MD_SVC};

   logic [DATA_W-1:0] cur_q;
   logic [DATA_W-1:0] saved_q [NUM_EXC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_q <= CUR_RESET;
      else if (st_wr_en)
         cur_q <= st_wr_data;
   end

   // One saved copy per exception bank; bank k+1 owns slot k.
   for (genvar g = 0; g < NUM_EXC; g++) begin : g_saved
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            saved_q[g] <= '0;
         else if (sv_wr_en && bank == bank_e'(g + 1))
            saved_q[g] <= sv_wr_data;
      end
   end

   always_comb begin
      sv_rd_data = cur_q;
      for (int k = 0; k < NUM_EXC; k++) begin
         if (bank == bank_e'(k + 1))
            sv_rd_data = saved_q[k];
      end
   end

   assign st_rd_data = cur_q;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bank_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FIQ_LO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   output logic [DATA_W-1:0] st_rd_data,
   input  logic              sv_wr_en,
   input  logic [DATA_W-1:0] sv_wr_data,
   output logic [DATA_W-1:0] sv_rd_data
);

   localparam int NRD = 2;

   bank_e                             bank;
   logic [NRD-1:0][ARCH_IDX_W-1:0]    rd_idx;
   logic [NRD-1:0][DATA_W-1:0]        rd_data;

   bank_mode_decode #(.MODE_BITS(MODE_W)) u_decode (
      .mode_i (mode_i),
      .bank_o (bank)
   );

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   bank_gpr_store #(
      .DATA_W   (DATA_W),
      .RD_PORTS (NRD),
      .FIQ_LO   (FIQ_LO)
   ) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank    (bank),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];

   bank_psr_store #(.DATA_W(DATA_W)) u_psr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank       (bank),
      .st_wr_en   (st_wr_en),
      .st_wr_data (st_wr_data),
      .st_rd_data (st_rd_data),
      .sv_wr_en   (sv_wr_en),
      .sv_wr_data (sv_wr_data),
      .sv_rd_data (sv_rd_data)
   );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode_i,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              st_wr_en,
   input logic [DATA_W-1:0] st_wr_data,
   input logic [DATA_W-1:0] st_rd_data,
   input logic              sv_wr_en,
   input logic [DATA_W-1:0] sv_wr_data,
   input logic [DATA_W-1:0] sv_rd_data
);

   logic exc_mode;
   assign exc_mode = (mode_i == 5'b10001) || (mode_i == 5'b10010) ||
                     (mode_i == 5'b10011) || (mode_i == 5'b10111) ||
                     (mode_i == 5'b11011);

   // R7: a written register shows the new value from the next cycle (port A)
   assert_write_visible_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!$stable(mode_i) || rd_a_idx != $past(wr_idx) ||
                 rd_a_data == $past(wr_data)));

   // R11: port B sees the same write independently of port A
   assert_write_visible_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!$stable(mode_i) || rd_b_idx != $past(wr_idx) ||
                 rd_b_data == $past(wr_data)));

   // R6: index 15 is shared, so a mode change does not hide the last write
   assert_pc_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == 4'hF) |=> (rd_a_idx != 4'hF || rd_a_data == $past(wr_data)));

   // R2: low indices are shared, so a mode change does not hide the last write
   assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_idx[3]) |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

   // R8: saved-status write in an exception mode is visible next cycle in that mode
   assert_saved_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sv_wr_en && exc_mode) |=> (!$stable(mode_i) || sv_rd_data == $past(sv_wr_data)));

   // R9: modes without a saved register read the current status
   assert_saved_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_mode |-> sv_rd_data == st_rd_data);

   // R10: current-status write visible next cycle whatever the mode
   assert_status_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_en |=> st_rd_data == $past(st_wr_data));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .rd_b_idx   (rd_b_idx),
   .rd_b_data  (rd_b_data),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .st_wr_en   (st_wr_en),
   .st_wr_data (st_wr_data),
   .st_rd_data (st_rd_data),
   .sv_wr_en   (sv_wr_en),
   .sv_wr_data (sv_wr_data),
   .sv_rd_data (sv_rd_data)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = 5'b10011;
   logic [3:0]  rd_a_idx = '0;
   logic [31:0] rd_a_data;
   logic [3:0]  rd_b_idx = '0;
   logic [31:0] rd_b_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        st_wr_en = 1'b0;
   logic [31:0] st_wr_data = '0;
   logic [31:0] st_rd_data;
   logic        sv_wr_en = 1'b0;
   logic [31:0] sv_wr_data = '0;
   logic [31:0] sv_rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   banked_regfile u_banked_regfile (.*);

   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                          SYS = 5'b11111, BAD = 5'b10101;

   // {mode, write enable, write index, write data, read index, expected read}
   localparam int NVEC = 17;
   localparam logic [77:0] VEC [NVEC] = '{
      {USR, 1'b1, 4'd8,  32'h11110008, 4'd8,  32'h00000000},  // R7 old value
      {USR, 1'b1, 4'd13, 32'hAAAA000D, 4'd8,  32'h11110008},  // R7 new value
      {FIQ, 1'b1, 4'd8,  32'hF1F10008, 4'd8,  32'h00000000},  // R3 private r8
      {FIQ, 1'b1, 4'd13, 32'hF1F1000D, 4'd8,  32'hF1F10008},  // R3
      {FIQ, 1'b0, 4'd0,  32'h00000000, 4'd13, 32'hF1F1000D},  // R3 private r13
      {USR, 1'b0, 4'd0,  32'h00000000, 4'd8,  32'h11110008},  // R3 user r8 kept
      {SYS, 1'b0, 4'd0,  32'h00000000, 4'd13, 32'hAAAA000D},  // R5 system = user
      {IRQ, 1'b1, 4'd14, 32'h1212000E, 4'd13, 32'h00000000},  // R4 irq r13
      {SVC, 1'b1, 4'd14, 32'h3333000E, 4'd14, 32'h00000000},  // R4 svc r14
      {IRQ, 1'b0, 4'd0,  32'h00000000, 4'd14, 32'h1212000E},  // R4 irq r14 kept
      {ABT, 1'b1, 4'd3,  32'h0A0A0003, 4'd8,  32'h11110008},  // R3 abort sees user r8
      {UND, 1'b1, 4'd15, 32'hCAFE0015, 4'd3,  32'h0A0A0003},  // R2 shared r3
      {FIQ, 1'b0, 4'd0,  32'h00000000, 4'd15, 32'hCAFE0015},  // R6 shared r15
      {FIQ, 1'b0, 4'd0,  32'h00000000, 4'd3,  32'h0A0A0003},  // R2
      {BAD, 1'b0, 4'd0,  32'h00000000, 4'd13, 32'hAAAA000D},  // R5 unlisted -> user
      {SVC, 1'b0, 4'd0,  32'h00000000, 4'd14, 32'h3333000E},  // R4
      {UND, 1'b0, 4'd0,  32'h00000000, 4'd14, 32'h00000000}   // R4 und r14 untouched
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      rd_a_idx = 4'd0; rd_b_idx = 4'd15; #1;
      check("R1 r0", rd_a_data, 32'h0);
      check("R1 r15", rd_b_data, 32'h0);
      check("R1 status", st_rd_data, 32'h00000013);
      check("R1 saved", sv_rd_data, 32'h0);
      mode_i = FIQ; rd_a_idx = 4'd14; #1;
      check("R1 fiq r14", rd_a_data, 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         {mode_i, wr_en, wr_idx, wr_data, rd_a_idx} = VEC[v][77:32];
         #2;
         check($sformatf("R7/vector %0d", v), rd_a_data, VEC[v][31:0]);
      end
      @(negedge clk);
      wr_en = 1'b0;

      // R11: both ports, different and equal indices
      mode_i = USR; rd_a_idx = 4'd8; rd_b_idx = 4'd13; #2;
      check("R11 port A", rd_a_data, 32'h11110008);
      check("R11 port B", rd_b_data, 32'hAAAA000D);
      mode_i = FIQ; rd_a_idx = 4'd8; rd_b_idx = 4'd8; #2;
      check("R11 same index", rd_b_data, 32'hF1F10008);

      // R8: saved status per exception mode
      @(negedge clk);
      mode_i = SVC; sv_wr_en = 1'b1; sv_wr_data = 32'h5;
      @(negedge clk);
      mode_i = IRQ; sv_wr_data = 32'h6;
      @(negedge clk);
      sv_wr_en = 1'b0; mode_i = SVC; #2;
      check("R8 svc saved", sv_rd_data, 32'h5);
      mode_i = IRQ; #2;
      check("R8 irq saved", sv_rd_data, 32'h6);
      mode_i = ABT; #2;
      check("R8 abt saved untouched", sv_rd_data, 32'h0);

      // R9: user-mode saved write ignored, read falls back to status
      @(negedge clk);
      mode_i = USR; sv_wr_en = 1'b1; sv_wr_data = 32'h77; #2;
      check("R9 user fallback", sv_rd_data, 32'h00000013);
      @(negedge clk);
      sv_wr_en = 1'b0; #2;
      check("R9 user after write", sv_rd_data, 32'h00000013);
      mode_i = SVC; #2;
      check("R9 svc unchanged", sv_rd_data, 32'h5);
      mode_i = FIQ; #2;
      check("R9 fiq unchanged", sv_rd_data, 32'h0);

      // R10: current status write
      @(negedge clk);
      st_wr_en = 1'b1; st_wr_data = 32'h000001F0; #2;
      check("R10 old status", st_rd_data, 32'h00000013);
      @(negedge clk);
      st_wr_en = 1'b0; #2;
      check("R10 new status", st_rd_data, 32'h000001F0);
      mode_i = SYS; #2;
      check("R10 status in system", st_rd_data, 32'h000001F0);
      check("R9 system fallback", sv_rd_data, 32'h000001F0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule